// File: doc/BRIEF.md
# CAN Bit Stuffing Encoder and Decoder

This block applies and removes the bit-stuffing line code of a CAN controller, one bit per bit-time strobe. On the transmit path the frame controller presents one frame bit at a time together with a stuffing-enable flag. The encoder copies the bit to the NRZ line output. Once it has placed five equal bits in a row inside a stuffed region, it sends one bit of the opposite level. For that one strobe it pulls its ready output low, so the source holds its bit and offers it again on the next strobe.

On the receive path the sampled line bit and a matching stuffing-enable flag come in on each strobe. The decoder passes data bits out with a one-cycle valid pulse. It drops the bit that follows five equal stuffed-region bits. If that dropped bit has the same level as the five before it, the decoder raises a one-cycle stuff-error pulse instead. The stuffing-enable inputs are low during the fixed-form fields (CRC delimiter, ACK, end of frame) and during error and overload frames, so those bits pass through unchanged. Sequencing of frame fields, CRC and bit timing are handled elsewhere.

Top module: `can_stuff_codec`

## Requirements
- R1: With `tx_stuff_en` high, after five consecutive equal bits on `tx_line` the next strobe emits the complementary level as a stuff bit.
- R2: An inserted stuff bit is the first bit of the next run. After 0,0,0,0,0 the stuff bit 1 followed by four frame 1s forces a further stuff bit 0.
- R3: While the stuffing enable is low, bits pass through unchanged and no stuff bit is inserted, however long the run is.
- R4: `tx_ready` is low for exactly the one strobe at which a stuff bit is emitted. The frame bit held during that strobe is emitted on the next strobe.
- R5: With `rx_stuff_en` high, the bit that follows five equal bits gives no `rx_valid` pulse. Every other strobe gives an `rx_valid` pulse with `rx_data` equal to the sampled bit.
- R6: `rx_stuff_err` pulses at a dropped bit exactly when that bit equals the five before it. It never pulses together with `rx_valid`.
- R7: If the enable falls right after a fifth equal stuffed bit, the pending stuff bit is still emitted (transmit) or dropped (receive) before the first unstuffed bit.
- R8: Bits received while the enable is low do not count towards a run. The count restarts at the first bit with the enable high.
- R9: During reset `tx_line` is recessive (1), `tx_ready` is 1, and `rx_valid` and `rx_stuff_err` are 0.
- R10: `tx_line` changes only on the clock edge where `bit_stb` is high. `rx_valid` and `rx_stuff_err` are high only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe per bit time, shared by both paths |
| tx_bit | input | 1 | Frame bit to transmit (1 = recessive) |
| tx_stuff_en | input | 1 | Transmit bit lies in a stuffed region |
| tx_ready | output | 1 | Frame bit is consumed at this strobe; low while a stuff bit is sent |
| tx_line | output | 1 | NRZ line bit, held for a full bit time |
| rx_line | input | 1 | Sampled line bit |
| rx_stuff_en | input | 1 | Received bit lies in a stuffed region |
| rx_data | output | 1 | Destuffed data bit |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` carries a new bit |
| rx_stuff_err | output | 1 | One-cycle pulse: stuffing rule violated |

## Verification
A run counter that has drifted by one shows up at the ports within six strobes. The stuff bit then appears one bit early or late on `tx_line`, or `tx_ready` drops at the wrong strobe, or a valid data bit goes missing on receive. A wrong stored previous level inverts the next stuff bit, or turns a legal stuff bit into a stuff-error pulse at that same strobe. The sweeps run every short stream pattern through both paths, with an unstuffed tail, so each of these faults shows up within a single frame.

// File: rtl/can_stuff_pkg.sv
// Shared constants and types for the CAN bit stuffing codec.
// Assumes: dominant is logic 0, recessive is logic 1.
package can_stuff_pkg;
    localparam int RUN_LEN_DEFAULT = 5;

    typedef enum logic {
        LVL_DOMINANT  = 1'b0,
        LVL_RECESSIVE = 1'b1
    } line_lvl_e;
endpackage

// File: rtl/can_run_track.sv
// Run tracker: counts equal consecutive line bits in a stuffed region and
// flags when the next bit on the line is a stuff bit.
// Assumes: stb is a single-cycle pulse; line_bit is the bit that is on the
// line for this strobe (a stuff bit included).
module can_run_track
    import can_stuff_pkg::*;
#(
    parameter int RUN_LEN = RUN_LEN_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic en,
    input  logic line_bit,
    output logic stuff_due,
    output logic last_bit
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

    logic [CNT_W-1:0] run_cnt;

    assign stuff_due = (run_cnt == RUN_MAX);

    // Update the run length and the previous level at each strobe; clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            last_bit <= logic'(LVL_RECESSIVE);
        end else if (stb) begin
            last_bit <= line_bit;
            if (stuff_due) begin
                run_cnt <= en ? RUN_ONE : '0;
            end else if (en) begin
                run_cnt <= (run_cnt != '0 && line_bit == last_bit) ? run_cnt + RUN_ONE : RUN_ONE;
            end else begin
                run_cnt <= '0;
            end
        end else if (!en && !stuff_due) begin
            run_cnt <= '0;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= RUN_MAX);  // R1
    AST_DISABLED_NO_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !stb && !stuff_due) |=> !stuff_due);  // R3
endmodule

// File: rtl/can_stuff_tx.sv
// Transmit encoder: copies frame bits to the NRZ line and inserts a stuff
// bit after each run of RUN_LEN equal bits in a stuffed region.
// Assumes: the source keeps tx_bit and en steady while tx_ready is low.
module can_stuff_tx
    import can_stuff_pkg::*;
#(
    parameter int RUN_LEN = RUN_LEN_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic tx_bit,
    input  logic tx_stuff_en,
    output logic tx_ready,
    output logic tx_line
);
    logic stuff_due;
    logic last_bit;
    logic line_nxt;

    // Choose between the stuff bit and the frame bit for this strobe.
    assign line_nxt = stuff_due ? ~last_bit : tx_bit;
    assign tx_ready = ~stuff_due;

    can_run_track #(.RUN_LEN(RUN_LEN)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (bit_stb),
        .en        (tx_stuff_en),
        .line_bit  (line_nxt),
        .stuff_due (stuff_due),
        .last_bit  (last_bit)
    );

    // Hold the line level for the whole bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_line <= logic'(LVL_RECESSIVE);
        end else if (bit_stb) begin
            tx_line <= line_nxt;
        end
    end

    AST_STUFF_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !tx_ready) |=> (tx_line == !$past(tx_line)));  // R1
    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !tx_ready) |=> tx_ready);  // R4
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(tx_line));  // R10
endmodule

// File: rtl/can_stuff_rx.sv
// Receive decoder: removes stuff bits from the sampled line stream and
// reports a stuff error when the bit after a full run does not toggle.
// Assumes: en reflects the field of the bit sampled at the same strobe.
module can_stuff_rx
    import can_stuff_pkg::*;
#(
    parameter int RUN_LEN = RUN_LEN_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic rx_line,
    input  logic rx_stuff_en,
    output logic rx_data,
    output logic rx_valid,
    output logic rx_stuff_err
);
    logic stuff_due;
    logic last_bit;

    can_run_track #(.RUN_LEN(RUN_LEN)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (bit_stb),
        .en        (rx_stuff_en),
        .line_bit  (rx_line),
        .stuff_due (stuff_due),
        .last_bit  (last_bit)
    );

    // Emit a data bit or drop a stuff bit at each strobe; pulses last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data      <= logic'(LVL_RECESSIVE);
            rx_valid     <= 1'b0;
            rx_stuff_err <= 1'b0;
        end else if (bit_stb) begin
            if (stuff_due) begin
                rx_valid     <= 1'b0;
                rx_stuff_err <= (rx_line == last_bit);
            end else begin
                rx_data      <= rx_line;
                rx_valid     <= 1'b1;
                rx_stuff_err <= 1'b0;
            end
        end else begin
            rx_valid     <= 1'b0;
            rx_stuff_err <= 1'b0;
        end
    end

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stuff_err |-> !rx_valid);  // R6
    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> (!rx_valid && !rx_stuff_err));  // R10
endmodule

// File: rtl/can_stuff_codec.sv
// CAN bit stuffing codec top: transmit encoder and receive decoder that share
// one bit-time strobe.
// Assumes: bit_stb is a single-cycle pulse with at least one idle cycle between strobes.
module can_stuff_codec
    import can_stuff_pkg::*;
#(
    parameter int RUN_LEN = RUN_LEN_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic tx_bit,
    input  logic tx_stuff_en,
    output logic tx_ready,
    output logic tx_line,
    input  logic rx_line,
    input  logic rx_stuff_en,
    output logic rx_data,
    output logic rx_valid,
    output logic rx_stuff_err
);
    can_stuff_tx #(.RUN_LEN(RUN_LEN)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .tx_bit      (tx_bit),
        .tx_stuff_en (tx_stuff_en),
        .tx_ready    (tx_ready),
        .tx_line     (tx_line)
    );

    can_stuff_rx #(.RUN_LEN(RUN_LEN)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_stb      (bit_stb),
        .rx_line      (rx_line),
        .rx_stuff_en  (rx_stuff_en),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_stuff_err (rx_stuff_err)
    );
endmodule

// File: tb/can_stuff_codec_tb.sv
module can_stuff_codec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RUN = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0;
    logic tx_bit = 1'b1;
    logic tx_stuff_en = 1'b0;
    logic tx_ready, tx_line;
    logic rx_line = 1'b1;
    logic rx_stuff_en = 1'b0;
    logic rx_data, rx_valid, rx_stuff_err;

    int tests = 0;
    int fails = 0;

    // transmit and receive reference state
    int   m_tx_run = 0;
    logic m_tx_last = 1'b1;
    int   m_rx_run = 0;
    logic m_rx_last = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_stuff_codec #(.RUN_LEN(RUN)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
        .tx_bit(tx_bit), .tx_stuff_en(tx_stuff_en), .tx_ready(tx_ready), .tx_line(tx_line),
        .rx_line(rx_line), .rx_stuff_en(rx_stuff_en),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_stuff_err(rx_stuff_err)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One transmit strobe; took reports whether the frame bit was consumed.
    task automatic tx_step(input logic b, input logic en, input string lbl, output logic took);
        logic exp_line;
        logic stall;
        @(negedge clk);
        stall = (m_tx_run == RUN);
        chk(tx_ready == !stall, "R4", 32'(tx_ready), 32'(!stall));
        tx_bit = b; tx_stuff_en = en; bit_stb = 1'b1;
        if (stall) begin
            exp_line = ~m_tx_last;
            m_tx_run = en ? 1 : 0;
        end else begin
            exp_line = b;
            if (en) m_tx_run = (m_tx_run != 0 && b == m_tx_last) ? m_tx_run + 1 : 1;
            else    m_tx_run = 0;
        end
        m_tx_last = exp_line;
        @(negedge clk);
        bit_stb = 1'b0;
        chk(tx_line == exp_line, stall ? "R1" : lbl, 32'(tx_line), 32'(exp_line));
        took = !stall;
    endtask

    // Feed n frame bits (LSB first) through the encoder, honouring stalls.
    task automatic tx_seq(input logic [15:0] bits, input logic [15:0] ens, input int n, input string lbl);
        int i = 0;
        logic took;
        while (i < n) begin
            tx_step(bits[i], ens[i], lbl, took);
            if (took) i++;
        end
    endtask

    // One receive strobe with checks on the pulses that follow it.
    task automatic rx_step(input logic b, input logic en, input string lbl);
        logic exp_valid;
        logic exp_err;
        @(negedge clk);
        chk(!rx_valid && !rx_stuff_err, "R10", {30'd0, rx_valid, rx_stuff_err}, 32'd0);
        rx_line = b; rx_stuff_en = en; bit_stb = 1'b1;
        if (m_rx_run == RUN) begin
            exp_valid = 1'b0;
            exp_err = (b == m_rx_last);
            m_rx_run = en ? 1 : 0;
        end else begin
            exp_valid = 1'b1;
            exp_err = 1'b0;
            if (en) m_rx_run = (m_rx_run != 0 && b == m_rx_last) ? m_rx_run + 1 : 1;
            else    m_rx_run = 0;
        end
        m_rx_last = b;
        @(negedge clk);
        bit_stb = 1'b0;
        chk(rx_valid == exp_valid, lbl, 32'(rx_valid), 32'(exp_valid));
        chk(rx_stuff_err == exp_err, "R6", 32'(rx_stuff_err), 32'(exp_err));
        if (exp_valid) chk(rx_data == b, lbl, 32'(rx_data), 32'(b));
    endtask

    task automatic rx_seq(input logic [15:0] bits, input logic [15:0] ens, input int n, input string lbl);
        for (int i = 0; i < n; i++) rx_step(bits[i], ens[i], lbl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(tx_line == 1'b1, "R9", 32'(tx_line), 32'd1);
        chk(tx_ready == 1'b1, "R9", 32'(tx_ready), 32'd1);
        chk(!rx_valid && !rx_stuff_err, "R9", {30'd0, rx_valid, rx_stuff_err}, 32'd0);
        rst_n = 1'b1;

        // R3: long dominant run with stuffing disabled
        tx_seq(16'h0000, 16'h0000, 8, "R3");
        // R8: earlier disabled zeros do not count; five enabled zeros then stuff
        tx_seq(16'h0000, 16'h003F, 6, "R8");
        tx_seq(16'hFFFF, 16'h0000, 2, "R3");
        // R2: 00000 -> stuff 1, then 1111 completes a run -> stuff 0
        tx_seq(16'h03E0, 16'h03FF, 10, "R2");
        tx_seq(16'hFFFF, 16'h0000, 2, "R3");
        // R7: enable falls right after a fifth equal bit
        tx_seq(16'h001F, 16'h001F, 7, "R7");

        // R1: sweep all 9-bit stuffed frames with an unstuffed recessive tail
        for (int p = 0; p < 512; p++)
            tx_seq({7'h7F, 9'(p)}, 16'h01FF, 12, "R1");

        tx_bit = 1'b1; tx_stuff_en = 1'b0;

        // R6: six equal stuffed bits raise an error
        rx_seq(16'h0000, 16'h003F, 6, "R5");
        rx_seq(16'hFFFF, 16'h0000, 2, "R5");
        // R7 receive: pending stuff bit dropped after enable falls
        rx_seq(16'h0020, 16'h001F, 7, "R7");
        // R8 receive: disabled run followed by enabled bits
        rx_seq(16'h0000, 16'h0000, 7, "R8");
        rx_seq(16'h0020, 16'h003F, 7, "R8");

        // R5: sweep all 10-bit line patterns with an unstuffed tail
        for (int p = 0; p < 1024; p++)
            rx_seq({6'h3F, 10'(p)}, 16'h03FF, 12, "R5");

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule